// File: doc/BRIEF.md
# Two-Mode Sample Capture Buffer Sequencer

This block drives a bank of external byte-wide static memories that serve as one long linear sample store. It works in two exclusive modes. In capture mode, each sample request gates one of two ADC sources onto the shared byte bus and writes that byte at the current linear address. In replay mode, the stored bytes are read back one at a time and handed to a serial transmitter through a valid/ready handshake. A single linear address counter serves both modes. Its low bits form the address inside a chip. The bits just above them choose which chip select is driven low.

The highest address written during capture is kept. Replay stops, and a done flag rises, once the byte at that address has been accepted. Two ways of choosing the channel are offered. The first alternates between the two sources, or takes the first source only. The second uses the counter's lowest bit to choose the source, and in that case a single-channel request has no effect. A capture request made when the populated range is already full is not performed. It sets a sticky overflow flag instead.

Top module: `capbuf_seq`

## Requirements
- R1: After reset every chip select is high, write enable and output enable are high, no ADC is selected, tx_valid is low, and done and overflow are low.
- R2: A start of either mode is accepted only in the idle state and clears the linear address to zero, so mem_addr reads 0 on the cycle after the start. If both starts arrive together, capture wins.
- R3: A capture write takes three cycles after the request. In the first, the chosen ADC is selected and its byte is captured. In the second, mem_we_n is low for exactly one clock. In the third, mem_we_n is high with address and data unchanged. The address advances by one at the end of the third cycle.
- R4: During an access, only the chip whose index equals address bits [CHIP_AW+1:CHIP_AW] has its active-low select driven low, and it sees the lower CHIP_AW bits as its address. Outside an access, all selects are high.
- R5: mem_oe_n goes low only during the single read cycle of replay, and it is never low while adc_sel is nonzero.
- R6: With chan_by_addr=0 and single_chan=0, successive samples alternate between the sources, starting with source 0. With chan_by_addr=0 and single_chan=1, every sample uses source 0. adc_sel bit k selects source k.
- R7: With chan_by_addr=1, the source is bit 0 of the address being written, and single_chan has no effect.
- R8: A sample request that arrives when the address equals NUM_CHIPS*2^CHIP_AW performs no write and sets overflow. Overflow then stays high, and it blocks all further writes until the next capture start.
- R9: In replay, each byte is read in one cycle and then presented with tx_valid high. tx_data holds the stored byte at that address, and both are held until tx_ready is high. The address then advances.
- R10: Once the byte at the highest written address has been accepted, done rises and the block goes idle. A replay with no stored byte raises done at once. Done stays high until the next accepted start.
- R11: A replay start during capture is ignored, and a capture start during replay is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acq_start | input | 1 | Begin capture mode (pulse) |
| acq_stop | input | 1 | End capture mode (pulse) |
| dl_start | input | 1 | Begin replay mode (pulse) |
| chan_by_addr | input | 1 | Source chosen by address bit 0, latched at capture start |
| single_chan | input | 1 | Source 0 only when not address-chosen, latched at capture start |
| sample_req | input | 1 | Store one sample |
| adc_data | input | DATA_W | Byte from the selected ADC |
| adc_sel | output | 2 | One-hot ADC output enable |
| mem_addr | output | CHIP_AW | Address inside the selected chip |
| mem_cs_n | output | NUM_CHIPS | Active-low chip selects |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low memory output enable |
| mem_dout | output | DATA_W | Byte written to memory |
| mem_din | input | DATA_W | Byte read from memory |
| tx_data | output | DATA_W | Byte offered to the transmitter |
| tx_valid | output | 1 | tx_data is valid |
| tx_ready | input | 1 | Transmitter accepts the byte |
| done | output | 1 | Replay reached the highest written address |
| overflow | output | 1 | Sticky: capture went past the populated range |

## Verification
A wrong address count or a wrong chip decode appears on the next access. It shows as a wrong chip select or address during a write pulse. The same error also returns the wrong byte, or the wrong number of bytes, on replay. A lost or corrupted end marker shows up as done rising too early, too late or never, and it appears at the end of the same replay. The bench compares every strobe, select, address, flag and transmitted byte against its behavioural model on every clock, so a fault in the channel choice or the overflow state shows within one cycle of the access that exposes it.

// File: rtl/capbuf_pkg.sv
package capbuf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACQ,
    ST_WSET,
    ST_WPUL,
    ST_WDONE,
    ST_DL,
    ST_RSET,
    ST_RXMT
  } cap_state_t;
endpackage

// File: rtl/capbuf_addr_ctr.sv
module capbuf_addr_ctr #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              inc,
  output logic [ADDR_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end

  // R3: one step per completed access
  assert_ctr_step_R3: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr) |=> (cnt == $past(cnt) + 1'b1));
  // R2: clear takes the address to zero
  assert_ctr_clear_R2: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));
endmodule

// File: rtl/capbuf_chip_dec.sv
module capbuf_chip_dec #(
  parameter int CHIP_AW   = 19,
  parameter int NUM_CHIPS = 4,
  localparam int SEL_W    = $clog2(NUM_CHIPS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     active,
  input  logic [CHIP_AW+SEL_W-1:0] lin_addr,
  output logic [NUM_CHIPS-1:0]     cs_n,
  output logic [CHIP_AW-1:0]       chip_addr
);
  logic [SEL_W-1:0] chip_idx;
  assign chip_idx  = lin_addr[CHIP_AW +: SEL_W];
  assign chip_addr = lin_addr[CHIP_AW-1:0];

  for (genvar i = 0; i < NUM_CHIPS; i++) begin : g_cs
    assign cs_n[i] = !(active && (chip_idx == SEL_W'(i)));
  end

  // R4: never more than one chip on the bus
  assert_cs_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n));
  // R4: an access always enables exactly one chip
  assert_cs_active_R4: assert property (@(posedge clk) disable iff (rst)
    active |-> $onehot(~cs_n));
endmodule

// File: rtl/capbuf_chan_pick.sv
module capbuf_chan_pick (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic       cfg_addr,
  input  logic       cfg_single,
  input  logic       advance,
  input  logic       drive,
  input  logic       addr_lsb,
  output logic [1:0] adc_sel
);
  logic mode_addr, mode_single, tog, chan;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_addr   <= 1'b0;
      mode_single <= 1'b0;
      tog         <= 1'b0;
    end else if (load) begin
      mode_addr   <= cfg_addr;
      mode_single <= cfg_single;
      tog         <= 1'b0;
    end else if (advance) begin
      tog <= ~tog;
    end
  end

  always_comb begin
    if (mode_addr)        chan = addr_lsb;
    else if (mode_single) chan = 1'b0;
    else                  chan = tog;
  end

  assign adc_sel = drive ? (chan ? 2'b10 : 2'b01) : 2'b00;

  // R6: at most one source drives the bus
  assert_sel_onehot_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(adc_sel));
  // R6: single-source capture never selects source 1
  assert_single_src_R6: assert property (@(posedge clk) disable iff (rst)
    (drive && !mode_addr && mode_single) |-> (adc_sel == 2'b01));
  // R7: address-chosen source follows the address parity
  assert_addr_src_R7: assert property (@(posedge clk) disable iff (rst)
    (drive && mode_addr) |-> (adc_sel[1] == addr_lsb));
endmodule

// File: rtl/capbuf_fsm.sv
module capbuf_fsm
  import capbuf_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 8,
  parameter int CHIP_AW   = 19,
  parameter int NUM_CHIPS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acq_start,
  input  logic              acq_stop,
  input  logic              dl_start,
  input  logic              sample_req,
  input  logic              tx_ready,
  input  logic [DATA_W-1:0] adc_data,
  input  logic [DATA_W-1:0] mem_din,
  input  logic [ADDR_W-1:0] cnt,
  output logic              ctr_clr,
  output logic              ctr_inc,
  output logic              cfg_load,
  output logic              src_adv,
  output logic              src_drive,
  output logic              access,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dout,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_valid,
  output logic              done,
  output logic              overflow
);
  localparam logic [ADDR_W:0] POP = (ADDR_W+1)'(NUM_CHIPS) << CHIP_AW;

  cap_state_t        st, st_n;
  logic [ADDR_W-1:0] top;
  logic              top_v;
  logic              full;
  logic              stored_all;

  assign full       = ({1'b0, cnt} >= POP);
  assign stored_all = !top_v || (cnt > top);

  always_comb begin
    st_n = st;
    case (st)
      ST_IDLE:  if (acq_start) st_n = ST_ACQ;
                else if (dl_start) st_n = ST_DL;
      ST_ACQ:   if (acq_stop) st_n = ST_IDLE;
                else if (sample_req && !overflow && !full) st_n = ST_WSET;
      ST_WSET:  st_n = ST_WPUL;
      ST_WPUL:  st_n = ST_WDONE;
      ST_WDONE: st_n = ST_ACQ;
      ST_DL:    st_n = stored_all ? ST_IDLE : ST_RSET;
      ST_RSET:  st_n = ST_RXMT;
      ST_RXMT:  if (tx_ready) st_n = ST_DL;
      default:  st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      top      <= '0;
      top_v    <= 1'b0;
      done     <= 1'b0;
      overflow <= 1'b0;
      mem_dout <= '0;
      tx_data  <= '0;
    end else begin
      st <= st_n;
      case (st)
        ST_IDLE: begin
          if (acq_start) begin
            top_v    <= 1'b0;
            done     <= 1'b0;
            overflow <= 1'b0;
          end else if (dl_start) begin
            done <= 1'b0;
          end
        end
        ST_ACQ:   if (!acq_stop && sample_req && !overflow && full) overflow <= 1'b1;
        ST_WSET:  mem_dout <= adc_data;
        ST_WDONE: begin
          top   <= cnt;
          top_v <= 1'b1;
        end
        ST_DL:    if (stored_all) done <= 1'b1;
        ST_RSET:  tx_data <= mem_din;
        default:  ;
      endcase
    end
  end

  assign ctr_clr   = (st == ST_IDLE) && (acq_start || dl_start);
  assign ctr_inc   = (st == ST_WDONE) || ((st == ST_RXMT) && tx_ready);
  assign cfg_load  = (st == ST_IDLE) && acq_start;
  assign src_adv   = (st == ST_WDONE);
  assign src_drive = (st == ST_WSET);
  assign access    = (st == ST_WSET) || (st == ST_WPUL) || (st == ST_WDONE) || (st == ST_RSET);
  assign mem_we_n  = (st != ST_WPUL);
  assign mem_oe_n  = (st != ST_RSET);
  assign tx_valid  = (st == ST_RXMT);

  // R8: overflow stays until the next accepted capture start
  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (overflow && !((st == ST_IDLE) && acq_start)) |=> overflow);
  // R8: no write once overflow is set
  assert_no_overflow_write_R8: assert property (@(posedge clk) disable iff (rst)
    overflow |-> mem_we_n);
  // R9: offered byte held until accepted
  assert_tx_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  // R10: done stays until the next accepted start
  assert_done_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (done && !((st == ST_IDLE) && (acq_start || dl_start))) |=> done);
  // R11: a replay start cannot interrupt capture
  assert_mode_excl_R11: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_ACQ) && dl_start && !acq_stop) |=> (st != ST_DL));
endmodule

// File: rtl/capbuf_seq.sv
module capbuf_seq #(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 8,
  parameter int CHIP_AW   = 19,
  parameter int NUM_CHIPS = 4,
  localparam int SEL_W    = $clog2(NUM_CHIPS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 acq_start,
  input  logic                 acq_stop,
  input  logic                 dl_start,
  input  logic                 chan_by_addr,
  input  logic                 single_chan,
  input  logic                 sample_req,
  input  logic [DATA_W-1:0]    adc_data,
  output logic [1:0]           adc_sel,
  output logic [CHIP_AW-1:0]   mem_addr,
  output logic [NUM_CHIPS-1:0] mem_cs_n,
  output logic                 mem_we_n,
  output logic                 mem_oe_n,
  output logic [DATA_W-1:0]    mem_dout,
  input  logic [DATA_W-1:0]    mem_din,
  output logic [DATA_W-1:0]    tx_data,
  output logic                 tx_valid,
  input  logic                 tx_ready,
  output logic                 done,
  output logic                 overflow
);
  logic [ADDR_W-1:0] cnt;
  logic ctr_clr, ctr_inc, cfg_load, src_adv, src_drive, access;

  capbuf_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk(clk), .rst(rst), .clr(ctr_clr), .inc(ctr_inc), .cnt(cnt)
  );

  capbuf_chip_dec #(.CHIP_AW(CHIP_AW), .NUM_CHIPS(NUM_CHIPS)) u_dec (
    .clk(clk), .rst(rst), .active(access),
    .lin_addr(cnt[CHIP_AW+SEL_W-1:0]),
    .cs_n(mem_cs_n), .chip_addr(mem_addr)
  );

  capbuf_chan_pick u_pick (
    .clk(clk), .rst(rst), .load(cfg_load),
    .cfg_addr(chan_by_addr), .cfg_single(single_chan),
    .advance(src_adv), .drive(src_drive), .addr_lsb(cnt[0]),
    .adc_sel(adc_sel)
  );

  capbuf_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHIP_AW(CHIP_AW), .NUM_CHIPS(NUM_CHIPS)
  ) u_fsm (
    .clk(clk), .rst(rst),
    .acq_start(acq_start), .acq_stop(acq_stop), .dl_start(dl_start),
    .sample_req(sample_req), .tx_ready(tx_ready),
    .adc_data(adc_data), .mem_din(mem_din), .cnt(cnt),
    .ctr_clr(ctr_clr), .ctr_inc(ctr_inc), .cfg_load(cfg_load),
    .src_adv(src_adv), .src_drive(src_drive), .access(access),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dout(mem_dout),
    .tx_data(tx_data), .tx_valid(tx_valid), .done(done), .overflow(overflow)
  );

  // R5: memory and ADC never drive the shared bus together
  assert_bus_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(!mem_oe_n && (adc_sel != 2'b00)));
  // R3: write pulse lasts one clock
  assert_we_one_cycle_R3: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |=> mem_we_n);
  // R3: address, select and data held across write release
  assert_we_stable_R3: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |=> ($stable(mem_addr) && $stable(mem_dout) && $stable(mem_cs_n)));
  // R5: a write and a read never overlap
  assert_we_oe_excl_R5: assert property (@(posedge clk) disable iff (rst)
    mem_we_n || mem_oe_n);
endmodule

// File: tb/sim_capbuf_seq.sv
module sim_capbuf_seq;
  localparam int CAW = 3;
  localparam int NCH = 4;
  localparam int POP = NCH << CAW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, acq_start, acq_stop, dl_start, chan_by_addr, single_chan, sample_req, tx_ready;
  logic [7:0] adc_data, mem_dout, mem_din, tx_data;
  logic [1:0] adc_sel;
  logic [CAW-1:0] mem_addr;
  logic [NCH-1:0] mem_cs_n;
  logic mem_we_n, mem_oe_n, tx_valid, done, overflow;

  capbuf_seq #(.ADDR_W(24), .DATA_W(8), .CHIP_AW(CAW), .NUM_CHIPS(NCH)) u0 (
    .clk(clk), .rst(rst), .acq_start(acq_start), .acq_stop(acq_stop), .dl_start(dl_start),
    .chan_by_addr(chan_by_addr), .single_chan(single_chan), .sample_req(sample_req),
    .adc_data(adc_data), .adc_sel(adc_sel), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dout(mem_dout), .mem_din(mem_din),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .done(done), .overflow(overflow)
  );

  int checks = 0;
  int errors = 0;
  int accepted = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ADC sources and external memory
  logic [7:0] v0, v1;
  logic [7:0] sram [POP];
  assign adc_data = adc_sel[1] ? v1 : v0;

  function automatic int chip_of(logic [NCH-1:0] csn);
    for (int i = 0; i < NCH; i++) if (csn[i] == 1'b0) return i;
    return 0;
  endfunction

  always_comb mem_din = sram[chip_of(mem_cs_n) * (1 << CAW) + int'(mem_addr)];

  always @(negedge clk) if (mem_we_n === 1'b0)
    sram[chip_of(mem_cs_n) * (1 << CAW) + int'(mem_addr)] = mem_dout;

  // behavioural reference: 0 idle,1 capture,2-4 write steps,5 replay,6 read,7 offer
  int ph, ptr, top, topv, m_ovf, m_done, tog, cfg_a, cfg_s;
  logic [7:0] exp_mem [POP];

  function automatic int src_now();
    if (cfg_a != 0) return ptr & 1;
    if (cfg_s != 0) return 0;
    return tog;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      ph = 0; ptr = 0; top = 0; topv = 0; m_ovf = 0; m_done = 0; tog = 0;
      cfg_a = 0; cfg_s = 0; v0 = 8'h00; v1 = 8'h80;
    end else begin
      case (ph)
        0: if (acq_start) begin
             ph = 1; ptr = 0; tog = 0; m_ovf = 0; m_done = 0; topv = 0;
             cfg_a = int'(chan_by_addr); cfg_s = int'(single_chan);
           end else if (dl_start) begin
             ph = 5; ptr = 0; m_done = 0;
           end
        1: if (acq_stop) ph = 0;
           else if (sample_req && m_ovf == 0) begin
             if (ptr >= POP) m_ovf = 1; else ph = 2;
           end
        2: begin exp_mem[ptr] = (src_now() == 1) ? v1 : v0; ph = 3; end
        3: ph = 4;
        4: begin
             if (src_now() == 1) v1 = v1 + 8'd1; else v0 = v0 + 8'd1;
             top = ptr; topv = 1; ptr++; tog ^= 1; ph = 1;
           end
        5: if (topv == 0 || ptr > top) begin m_done = 1; ph = 0; end else ph = 6;
        6: ph = 7;
        7: if (tx_ready) begin ptr++; ph = 5; end
        default: ph = 0;
      endcase
    end
  end

  // per-clock comparison
  always @(negedge clk) if (!rst) begin
    bit act;
    logic [NCH-1:0] exp_cs;
    logic [1:0] exp_sel;
    act = (ph == 2 || ph == 3 || ph == 4 || ph == 6);
    exp_cs = act ? ~(NCH'(1) << (ptr >> CAW)) : '1;
    exp_sel = (ph == 2) ? ((src_now() == 1) ? 2'b10 : 2'b01) : 2'b00;
    chk(mem_cs_n == exp_cs, "R4", "mem_cs_n", int'(mem_cs_n), int'(exp_cs));
    chk(int'(mem_addr) == (ptr & ((1 << CAW) - 1)), "R2", "mem_addr", int'(mem_addr), ptr & ((1 << CAW) - 1));
    chk(mem_we_n == (ph != 3), "R3", "mem_we_n", int'(mem_we_n), int'(ph != 3));
    chk(mem_oe_n == (ph != 6), "R5", "mem_oe_n", int'(mem_oe_n), int'(ph != 6));
    chk(adc_sel == exp_sel, (cfg_a != 0) ? "R7" : "R6", "adc_sel", int'(adc_sel), int'(exp_sel));
    chk(tx_valid == (ph == 7), "R9", "tx_valid", int'(tx_valid), int'(ph == 7));
    chk(int'(done) == m_done, "R10", "done", int'(done), m_done);
    chk(int'(overflow) == m_ovf, "R8", "overflow", int'(overflow), m_ovf);
    if (ph == 3) chk(mem_dout == exp_mem[ptr], "R3", "mem_dout", int'(mem_dout), int'(exp_mem[ptr]));
    if (ph == 7) chk(tx_data == exp_mem[ptr], "R9", "tx_data", int'(tx_data), int'(exp_mem[ptr]));
    if (tx_valid && tx_ready) accepted++;
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_acq(bit a, bit s);
    chan_by_addr = a; single_chan = s; acq_start = 1'b1;
    tick(1);
    acq_start = 1'b0;
    chk(mem_addr == '0, "R2", "addr after capture start", int'(mem_addr), 0);
  endtask

  task automatic take(int n);
    for (int i = 0; i < n; i++) begin
      sample_req = 1'b1; tick(1); sample_req = 1'b0; tick(4);
    end
  endtask

  task automatic stop_acq();
    acq_stop = 1'b1; tick(1); acq_stop = 1'b0; tick(1);
  endtask

  task automatic replay(int nbytes, int stall, bit poke);
    int k;
    accepted = 0;
    dl_start = 1'b1; tick(1); dl_start = 1'b0;
    chk(mem_addr == '0, "R2", "addr after replay start", int'(mem_addr), 0);
    k = 0;
    while (!done && k < 2000) begin
      tx_ready = (stall == 0) ? 1'b1 : ((k % stall) != 0);
      acq_start = (poke && k == 3);
      tick(1);
      k++;
    end
    tx_ready = 1'b0; acq_start = 1'b0;
    chk(done == 1'b1, "R10", "done after replay", int'(done), 1);
    chk(accepted == nbytes, "R9", "bytes replayed", accepted, nbytes);
    tick(2);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; acq_start = 0; acq_stop = 0; dl_start = 0; chan_by_addr = 0;
    single_chan = 0; sample_req = 0; tx_ready = 0;
    tick(3);
    chk(mem_cs_n == '1 && mem_we_n && mem_oe_n && adc_sel == 2'b00 && !tx_valid && !done && !overflow,
        "R1", "idle outputs after reset", int'({done, overflow, tx_valid, adc_sel}), 0);
    rst = 1'b0;
    tick(2);
    chk(mem_cs_n == '1 && !done, "R1", "idle after reset release", int'(mem_cs_n), (1 << NCH) - 1);

    // alternating sources, replay start during capture is ignored
    start_acq(1'b0, 1'b0);
    take(3);
    dl_start = 1'b1; tick(1); dl_start = 1'b0; tick(2);
    chk(mem_oe_n && !tx_valid, "R11", "replay start during capture", int'(mem_oe_n), 1);
    take(3);
    stop_acq();
    replay(6, 3, 1'b0);

    // source 0 only
    start_acq(1'b0, 1'b1);
    take(5);
    stop_acq();
    replay(5, 0, 1'b1);
    chk(overflow == 1'b0, "R11", "capture start during replay ignored", int'(overflow), 0);

    // address-chosen source, single request has no effect
    start_acq(1'b1, 1'b1);
    sample_req = 1'b1; tick(1); sample_req = 1'b0;
    chk(adc_sel == 2'b01, "R7", "even address source", int'(adc_sel), 1);
    tick(4);
    sample_req = 1'b1; tick(1); sample_req = 1'b0;
    chk(adc_sel == 2'b10, "R7", "odd address source", int'(adc_sel), 2);
    tick(4);
    take(4);
    stop_acq();
    replay(6, 2, 1'b0);

    // fill every chip, then overflow
    start_acq(1'b0, 1'b0);
    take(POP);
    chk(overflow == 1'b0, "R8", "no overflow at full count", int'(overflow), 0);
    sample_req = 1'b1; tick(1); sample_req = 1'b0; tick(1);
    chk(overflow == 1'b1, "R8", "overflow set", int'(overflow), 1);
    take(2);
    chk(overflow == 1'b1 && mem_we_n, "R8", "overflow sticky, no write", int'(overflow), 1);
    stop_acq();
    replay(POP, 0, 1'b0);
    chk(overflow == 1'b1, "R8", "overflow held through replay", int'(overflow), 1);

    // empty capture then replay
    start_acq(1'b0, 1'b0);
    chk(overflow == 1'b0, "R8", "overflow cleared by capture start", int'(overflow), 0);
    stop_acq();
    replay(0, 0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule